// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Bounded-Rate Squash

This block keeps the in-flight instructions of a few hardware threads in program order so that they can retire in order. A dispatch stage writes one instruction per cycle (thread number, sequence number, result tag) at the young end of that thread's queue. Execution units mark slots as finished. Each thread retires from its old end only, and only when the oldest entry is finished. The total entry budget is shared among the threads under one of three sharing modes chosen at run time: dynamic, partitioned or threshold.

When a thread mispredicts, a squash request names the thread and a sequence number. Every instruction of that thread that is younger than the given number is removed. Removal happens in two phases. First, a walk pointer moves from the young end toward the old end and marks at most `SQW` entries per cycle. The walk pointer keeps its place between cycles, and the tail stays fixed while it moves. When the walk reaches the squash point, a per-thread done flag rises. The marked entries are then released from the tail, one per cycle. The thread accepts no dispatch and no retirement until the release is finished.

The dispatch port is a valid/ready stream. An entry is accepted on a clock edge where `disp_valid` and `disp_ready` are both high. Holding `disp_valid` high while `disp_ready` is low loses nothing. The retire side is one stream per thread. `can_commit[t]` acts as valid, `head_tag[t]` carries the data, and `commit_req[t]` acts as ready. The head moves forward on an edge where both are high.

Top module: `rob_mt`

## Requirements
- R1: After reset every thread count is zero, `empty` and all `thr_empty` bits are 1, every `thr_state` is idle (0), every `sq_done` bit is 1, and `any_commit` is 0.
- R2: An accepted dispatch writes its entry at `tail_slot[t]` of the chosen thread. The tail then advances by one modulo `N`, and `thr_empty[t]` clears.
- R3: `disp_ready` is low when the chosen thread's free count is zero, when that thread is squashing, or when a squash request for that thread is present in the same cycle. `full` is 1 exactly when the total occupancy equals `N`.
- R4: The per-thread limit is 0 for a thread whose `cfg_active` bit is clear. For an active thread the limit depends on `cfg_mode`: mode 0 (dynamic) gives `N`; mode 1 (partitioned) gives floor(`N` / number of active threads); mode 2 (threshold) gives floor(`N` * min(pct,100) / 100). `free_cnt[t]` = min(max(limit − count, 0), `N` − total occupancy), and `thr_full[t]` = count ≥ limit. Both follow a configuration change in the same cycle.
- R5: A completion marks the addressed slot of the addressed thread as finished. Finishing a slot other than the head does not allow retirement.
- R6: `can_commit[t]` is 1 only when thread t is not empty, its head slot is finished, it is not squashing, and no squash request for it is present in the same cycle. `head_tag[t]` shows the head entry's tag. `commit_req[t]` together with `can_commit[t]` advances `head_slot[t]` by one at the next edge. `any_commit` is the OR of `can_commit`.
- R7: A squash removes exactly the entries of that thread whose sequence number is greater than the request's number, compared as unsigned values. Older and equal entries, and the other threads, are untouched.
- R8: From the edge that accepts a squash, `sq_done[t]` stays 0 while the walk examines up to `SQW` entries per edge. It rises on the edge where the walk meets an entry that is not younger, or runs out of entries. With k younger entries below an older one, this is floor(k/`SQW`)+1 edges after acceptance.
- R9: `tail_slot[t]` holds still during the walk. After the walk, one marked entry is released from the tail per edge. `thr_state[t]` stays squashing (2) until the last marked entry is released.
- R10: A squash request for a thread that is already squashing is ignored.
- R11: `thr_state[t]` encodes idle as 0 (no entries, not squashing), running as 1 (entries present), and squashing as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Sharing mode: 0 dynamic, 1 partitioned, 2 threshold |
| cfg_active | input | T | Active-thread mask |
| cfg_thresh_pct | input | 7 | Threshold-mode cap in percent |
| disp_valid | input | 1 | Dispatch request valid |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_thread | input | TW | Dispatch thread number |
| disp_seq | input | SW | Dispatch sequence number |
| disp_tag | input | GW | Dispatch result tag |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_thread | input | TW | Completion thread number |
| cmpl_slot | input | IW | Completion slot index |
| commit_req | input | T | Per-thread retire ready |
| can_commit | output | T | Per-thread head may retire |
| any_commit | output | 1 | Some thread may retire |
| head_tag | output | T×GW | Tag of each thread's head entry |
| sq_valid | input | 1 | Squash request |
| sq_thread | input | TW | Squash thread number |
| sq_seq | input | SW | Squash point sequence number |
| head_slot | output | T×IW | Per-thread head slot index |
| tail_slot | output | T×IW | Per-thread next write slot |
| free_cnt | output | T×CW | Per-thread free entries |
| thr_full | output | T | Thread at its limit |
| thr_empty | output | T | Thread holds no entries |
| full | output | 1 | Total occupancy equals N |
| empty | output | 1 | No entries in any thread |
| thr_state | output | T×2 | Per-thread state code |
| sq_done | output | T | Per-thread squash walk finished |

## Verification
The assertions assume that thread numbers on the inputs are below `T` and that completions name slots that are occupied. They also assume that each thread's sequence numbers rise in dispatch order without wrapping, because the squash comparison is a plain unsigned compare. The directed stimulus dispatches only when `disp_ready` is high. It uses small increasing sequence numbers within each thread, completes only slots it has just filled, and applies a reset before each scenario so that no state carries over between scenarios.

// File: rtl/rob_mt_pkg.sv
package rob_mt_pkg;
  typedef enum logic [1:0] {
    TS_IDLE   = 2'd0,
    TS_RUN    = 2'd1,
    TS_SQUASH = 2'd2
  } thr_state_e;

  typedef enum logic [1:0] {
    SM_DYNAMIC = 2'd0,
    SM_PART    = 2'd1,
    SM_THRESH  = 2'd2
  } share_mode_e;

  typedef enum logic [1:0] {
    QP_RUN  = 2'd0,
    QP_WALK = 2'd1,
    QP_RECL = 2'd2
  } q_phase_e;
endpackage

// File: rtl/rob_share_policy.sv
module rob_share_policy #(
  parameter int T  = 2,
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [1:0]          mode,
  input  logic [T-1:0]        active,
  input  logic [6:0]          thresh_pct,
  input  logic [T-1:0][CW-1:0] cnt,
  output logic [T-1:0][CW-1:0] free_cnt,
  output logic [T-1:0]        thr_full,
  output logic [CW-1:0]       total
);
  import rob_mt_pkg::*;

  int n_act;
  int part_lim;
  int thr_lim;
  int pct;
  int sum;
  int pool;
  int lim;
  int left;

  always_comb begin
    n_act = 0;
    sum   = 0;
    for (int t = 0; t < T; t++) begin
      n_act = n_act + int'(active[t]);
      sum   = sum + int'(cnt[t]);
    end
    part_lim = 0;
    for (int k = 1; k <= T; k++) begin
      if (n_act == k) part_lim = N / k;
    end
    pct     = (int'(thresh_pct) > 100) ? 100 : int'(thresh_pct);
    thr_lim = (N * pct) / 100;
    pool    = (sum >= N) ? 0 : (N - sum);
    total   = CW'(sum);
    for (int t = 0; t < T; t++) begin
      if (!active[t]) begin
        lim = 0;
      end else begin
        case (share_mode_e'(mode))
          SM_PART:   lim = part_lim;
          SM_THRESH: lim = thr_lim;
          default:   lim = N;
        endcase
      end
      left        = (int'(cnt[t]) >= lim) ? 0 : (lim - int'(cnt[t]));
      free_cnt[t] = CW'((left < pool) ? left : pool);
      thr_full[t] = (int'(cnt[t]) >= lim);
    end
  end
endmodule

// File: rtl/rob_thread_q.sv
module rob_thread_q #(
  parameter int DEPTH = 8,
  parameter int SQW   = 2,
  parameter int SW    = 16,
  parameter int GW    = 8,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [SW-1:0] push_seq,
  input  logic [GW-1:0] push_tag,
  input  logic          cmpl,
  input  logic [IW-1:0] cmpl_slot,
  input  logic          pop,
  input  logic          sq_start,
  input  logic [SW-1:0] sq_seq,
  output logic [IW-1:0] head_slot,
  output logic [IW-1:0] tail_slot,
  output logic [CW-1:0] count,
  output logic          head_ready,
  output logic [GW-1:0] head_tag,
  output logic          in_run,
  output logic          sq_done
);
  import rob_mt_pkg::*;

  logic [SW-1:0]    seq_q [DEPTH];
  logic [GW-1:0]    tag_q [DEPTH];
  logic [DEPTH-1:0] rdy_q;
  logic [DEPTH-1:0] kill_q;

  logic [IW-1:0] head_q, tail_q, walk_ptr_q;
  logic [CW-1:0] cnt_q, walk_left_q, kill_cnt_q;
  logic [SW-1:0] sq_ref_q;
  q_phase_e      phase_q;
  logic          done_q;

  logic [DEPTH-1:0] kill_set;
  logic [IW-1:0]    wp;
  logic [CW-1:0]    wl, nkill;
  logic             go, walk_end;
  logic [IW-1:0]    tail_m1;

  assign tail_m1 = tail_q - 1'b1;

  // Walk step: examine up to SQW entries from the young end.
  always_comb begin
    kill_set = '0;
    go       = 1'b1;
    wp       = walk_ptr_q;
    wl       = walk_left_q;
    nkill    = '0;
    for (int k = 0; k < SQW; k++) begin
      if (go && (wl != '0)) begin
        if (seq_q[wp] > sq_ref_q) begin
          kill_set[wp] = 1'b1;
          wp    = wp - 1'b1;
          wl    = wl - 1'b1;
          nkill = nkill + 1'b1;
        end else begin
          go = 1'b0;
        end
      end
    end
    walk_end = !go || (wl == '0);
  end

  always_ff @(posedge clk) begin
    if (push && phase_q == QP_RUN && !sq_start) begin
      seq_q[tail_q] <= push_seq;
      tag_q[tail_q] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      walk_ptr_q  <= '0;
      walk_left_q <= '0;
      kill_cnt_q  <= '0;
      sq_ref_q    <= '0;
      phase_q     <= QP_RUN;
      done_q      <= 1'b1;
      rdy_q       <= '0;
      kill_q      <= '0;
    end else begin
      if (cmpl) rdy_q[cmpl_slot] <= 1'b1;
      case (phase_q)
        QP_RUN: begin
          if (sq_start) begin
            walk_ptr_q  <= tail_m1;
            walk_left_q <= cnt_q;
            sq_ref_q    <= sq_seq;
            kill_cnt_q  <= '0;
            done_q      <= 1'b0;
            phase_q     <= QP_WALK;
          end else begin
            if (push) begin
              rdy_q[tail_q] <= 1'b0;
              tail_q        <= tail_q + 1'b1;
            end
            if (pop) head_q <= head_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
          end
        end
        QP_WALK: begin
          kill_q      <= kill_q | kill_set;
          walk_ptr_q  <= wp;
          walk_left_q <= wl;
          kill_cnt_q  <= kill_cnt_q + nkill;
          if (walk_end) begin
            done_q  <= 1'b1;
            phase_q <= ((kill_cnt_q + nkill) == '0) ? QP_RUN : QP_RECL;
          end
        end
        default: begin
          tail_q          <= tail_m1;
          cnt_q           <= cnt_q - 1'b1;
          kill_q[tail_m1] <= 1'b0;
          kill_cnt_q      <= kill_cnt_q - 1'b1;
          if (kill_cnt_q <= CW'(1)) phase_q <= QP_RUN;
        end
      endcase
    end
  end

  assign head_slot  = head_q;
  assign tail_slot  = tail_q;
  assign count      = cnt_q;
  assign head_ready = rdy_q[head_q] && (cnt_q != '0);
  assign head_tag   = tag_q[head_q];
  assign in_run     = (phase_q == QP_RUN);
  assign sq_done    = done_q;
endmodule

// File: rtl/rob_mt.sv
module rob_mt #(
  parameter int T   = 2,
  parameter int N   = 8,
  parameter int SQW = 2,
  parameter int SW  = 16,
  parameter int GW  = 8,
  parameter int TW  = (T > 1) ? $clog2(T) : 1,
  parameter int IW  = $clog2(N),
  parameter int CW  = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic [T-1:0]         cfg_active,
  input  logic [6:0]           cfg_thresh_pct,
  input  logic                 disp_valid,
  output logic                 disp_ready,
  input  logic [TW-1:0]        disp_thread,
  input  logic [SW-1:0]        disp_seq,
  input  logic [GW-1:0]        disp_tag,
  input  logic                 cmpl_valid,
  input  logic [TW-1:0]        cmpl_thread,
  input  logic [IW-1:0]        cmpl_slot,
  input  logic [T-1:0]         commit_req,
  output logic [T-1:0]         can_commit,
  output logic                 any_commit,
  output logic [T-1:0][GW-1:0] head_tag,
  input  logic                 sq_valid,
  input  logic [TW-1:0]        sq_thread,
  input  logic [SW-1:0]        sq_seq,
  output logic [T-1:0][IW-1:0] head_slot,
  output logic [T-1:0][IW-1:0] tail_slot,
  output logic [T-1:0][CW-1:0] free_cnt,
  output logic [T-1:0]         thr_full,
  output logic [T-1:0]         thr_empty,
  output logic                 full,
  output logic                 empty,
  output logic [T-1:0][1:0]    thr_state,
  output logic [T-1:0]         sq_done
);
  import rob_mt_pkg::*;

  logic [T-1:0][CW-1:0] cnt;
  logic [T-1:0]         head_ready, in_run, sq_hit, push;
  logic [CW-1:0]        total;
  logic                 disp_fire;

  rob_share_policy #(.T(T), .N(N), .CW(CW)) u_policy (
    .mode       (cfg_mode),
    .active     (cfg_active),
    .thresh_pct (cfg_thresh_pct),
    .cnt        (cnt),
    .free_cnt   (free_cnt),
    .thr_full   (thr_full),
    .total      (total)
  );

  always_comb begin
    disp_ready = 1'b0;
    for (int t = 0; t < T; t++) begin
      if (disp_thread == TW'(t))
        disp_ready = in_run[t] && (free_cnt[t] != '0) && !sq_hit[t];
    end
  end
  assign disp_fire = disp_valid && disp_ready;

  for (genvar t = 0; t < T; t++) begin : g_thr
    logic cmpl_t;
    assign sq_hit[t]     = sq_valid && (sq_thread == TW'(t));
    assign push[t]       = disp_fire && (disp_thread == TW'(t));
    assign cmpl_t        = cmpl_valid && (cmpl_thread == TW'(t));
    assign can_commit[t] = head_ready[t] && in_run[t] && !sq_hit[t];
    assign thr_empty[t]  = (cnt[t] == '0);
    assign thr_state[t]  = !in_run[t]       ? TS_SQUASH :
                           (cnt[t] != '0)   ? TS_RUN : TS_IDLE;

    rob_thread_q #(.DEPTH(N), .SQW(SQW), .SW(SW), .GW(GW), .IW(IW), .CW(CW)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push[t]),
      .push_seq   (disp_seq),
      .push_tag   (disp_tag),
      .cmpl       (cmpl_t),
      .cmpl_slot  (cmpl_slot),
      .pop        (commit_req[t] && can_commit[t]),
      .sq_start   (sq_hit[t] && in_run[t]),
      .sq_seq     (sq_seq),
      .head_slot  (head_slot[t]),
      .tail_slot  (tail_slot[t]),
      .count      (cnt[t]),
      .head_ready (head_ready[t]),
      .head_tag   (head_tag[t]),
      .in_run     (in_run[t]),
      .sq_done    (sq_done[t])
    );
  end

  assign any_commit = |can_commit;
  assign full       = (total == CW'(N));
  assign empty      = (total == '0);
endmodule

// File: rtl/rob_mt_chk.sv
module rob_mt_chk #(
  parameter int T  = 2,
  parameter int N  = 8,
  parameter int TW = 1,
  parameter int IW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 disp_ready,
  input logic                 full,
  input logic [T-1:0]         commit_req,
  input logic [T-1:0]         can_commit,
  input logic [T-1:0]         thr_empty,
  input logic                 sq_valid,
  input logic [TW-1:0]        sq_thread,
  input logic [T-1:0][IW-1:0] head_slot,
  input logic [T-1:0][IW-1:0] tail_slot,
  input logic [T-1:0][1:0]    thr_state,
  input logic [T-1:0]         sq_done
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready);

  for (genvar t = 0; t < T; t++) begin : g_chk
    a_r6_head_moves_on_retire_only: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_req[t] && can_commit[t]) |=> $stable(head_slot[t]));

    a_r6_empty_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
      thr_empty[t] |-> !can_commit[t]);

    a_r9_tail_hold_walk: assert property (@(posedge clk) disable iff (!rst_n)
      !sq_done[t] |=> $stable(tail_slot[t]));

    a_r8_squash_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid && sq_thread == TW'(t) && thr_state[t] != 2'd2)
        |=> (!sq_done[t] && thr_state[t] == 2'd2));
  end
endmodule

bind rob_mt rob_mt_chk #(.T(T), .N(N), .TW(TW), .IW(IW)) u_rob_mt_chk (.*);

// File: tb/test_rob_mt.sv
module test_rob_mt;
  localparam int T = 2, N = 8, SQW = 2, SW = 16, GW = 8, TW = 1, IW = 3, CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_mode;
  logic [T-1:0] cfg_active;
  logic [6:0] cfg_thresh_pct;
  logic disp_valid, disp_ready;
  logic [TW-1:0] disp_thread;
  logic [SW-1:0] disp_seq;
  logic [GW-1:0] disp_tag;
  logic cmpl_valid;
  logic [TW-1:0] cmpl_thread;
  logic [IW-1:0] cmpl_slot;
  logic [T-1:0] commit_req, can_commit;
  logic any_commit;
  logic [T-1:0][GW-1:0] head_tag;
  logic sq_valid;
  logic [TW-1:0] sq_thread;
  logic [SW-1:0] sq_seq;
  logic [T-1:0][IW-1:0] head_slot, tail_slot;
  logic [T-1:0][CW-1:0] free_cnt;
  logic [T-1:0] thr_full, thr_empty, sq_done;
  logic full, empty;
  logic [T-1:0][1:0] thr_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rob_mt #(.T(T), .N(N), .SQW(SQW), .SW(SW), .GW(GW)) i_rob_mt (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_mode = 2'd0; cfg_active = 2'b11; cfg_thresh_pct = 7'd50;
    disp_valid = 0; disp_thread = '0; disp_seq = '0; disp_tag = '0;
    cmpl_valid = 0; cmpl_thread = '0; cmpl_slot = '0; commit_req = '0;
    sq_valid = 0; sq_thread = '0; sq_seq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input int th, input int seq, input int tag);
    disp_valid = 1; disp_thread = TW'(th); disp_seq = SW'(seq); disp_tag = GW'(tag);
    @(negedge clk);
    disp_valid = 0;
  endtask

  task automatic complete(input int th, input int slot);
    cmpl_valid = 1; cmpl_thread = TW'(th); cmpl_slot = IW'(slot);
    @(negedge clk);
    cmpl_valid = 0;
  endtask

  task automatic retire(input int th);
    commit_req[th] = 1'b1;
    @(negedge clk);
    commit_req = '0;
  endtask

  task automatic wait_run(input int th);
    for (int i = 0; i < 30; i++) begin
      if (thr_state[th] != 2'd2) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty", empty, 1);
    chk("R1 thr_empty", thr_empty, 3);
    chk("R1 R11 state0", thr_state[0], 0);
    chk("R1 R11 state1", thr_state[1], 0);
    chk("R1 sq_done", sq_done, 3);
    chk("R1 any_commit", any_commit, 0);
    chk("R1 full", full, 0);
  endtask

  task automatic t_dispatch_commit();
    do_reset();
    push(0, 1, 8'hA1); push(0, 2, 8'hA2); push(0, 3, 8'hA3);
    chk("R2 tail advance", tail_slot[0], 3);
    chk("R2 thr_empty clear", thr_empty[0], 0);
    chk("R11 running", thr_state[0], 1);
    chk("R6 head_tag", head_tag[0], 8'hA1);
    chk("R6 not finished", can_commit[0], 0);
    complete(0, 1);
    chk("R5 non-head finish", can_commit[0], 0);
    complete(0, 0);
    chk("R5 head finished", can_commit[0], 1);
    chk("R6 any_commit", any_commit, 1);
    retire(0);
    chk("R6 head advance", head_slot[0], 1);
    chk("R6 next tag", head_tag[0], 8'hA2);
    chk("R6 next ready", can_commit[0], 1);
    retire(0);
    chk("R6 head advance2", head_slot[0], 2);
    chk("R6 head not ready", can_commit[0], 0);
    chk("R4 dynamic free", free_cnt[0], 7);
  endtask

  task automatic t_policy();
    do_reset();
    push(0, 1, 1); push(0, 2, 2); push(0, 3, 3);
    cfg_mode = 2'd1; #1;
    chk("R4 part free0", free_cnt[0], 1);
    chk("R4 part free1", free_cnt[1], 4);
    cfg_active = 2'b01; #1;
    chk("R4 part single free0", free_cnt[0], 5);
    chk("R4 inactive free1", free_cnt[1], 0);
    disp_thread = 1; disp_valid = 1; #1;
    chk("R3 inactive blocked", disp_ready, 0);
    disp_valid = 0;
    cfg_mode = 2'd2; cfg_active = 2'b11; cfg_thresh_pct = 7'd30; #1;
    chk("R4 thresh saturate", free_cnt[0], 0);
    chk("R4 thresh full", thr_full[0], 1);
    chk("R4 thresh free1", free_cnt[1], 2);
    cfg_thresh_pct = 7'd100; #1;
    chk("R4 pool bound", free_cnt[1], 5);
    @(negedge clk);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 5; i++) push(0, i + 1, i);
    for (int i = 0; i < 3; i++) push(1, i + 1, i);
    chk("R3 full", full, 1);
    chk("R3 free zero", free_cnt[0], 0);
    disp_thread = 0; disp_valid = 1; #1;
    chk("R3 no ready when full", disp_ready, 0);
    disp_valid = 0;
    @(negedge clk);
    chk("R3 tail unchanged", tail_slot[0], 5);
  endtask

  task automatic t_squash_walk();
    do_reset();
    for (int i = 0; i < 6; i++) push(0, 10 + i, 8'h10 + i);
    push(1, 10, 8'h77);
    complete(0, 0);
    sq_valid = 1; sq_thread = 0; sq_seq = 10;
    disp_valid = 1; disp_thread = 0; #1;
    chk("R3 same-cycle squash block", disp_ready, 0);
    chk("R6 same-cycle squash", can_commit[0], 0);
    @(negedge clk);
    sq_valid = 0; disp_valid = 0;
    chk("R8 accepted", sq_done[0], 0);
    chk("R11 squashing", thr_state[0], 2);
    chk("R6 blocked in walk", can_commit[0], 0);
    @(negedge clk);
    chk("R8 walk edge1", sq_done[0], 0);
    @(negedge clk);
    chk("R8 walk edge2", sq_done[0], 0);
    chk("R9 tail hold", tail_slot[0], 6);
    @(negedge clk);
    chk("R8 walk end", sq_done[0], 1);
    chk("R9 tail after walk", tail_slot[0], 6);
    repeat (4) @(negedge clk);
    chk("R9 reclaim rate", tail_slot[0], 2);
    chk("R9 still squashing", thr_state[0], 2);
    @(negedge clk);
    chk("R9 reclaim done", thr_state[0], 1);
    chk("R7 survivor tail", tail_slot[0], 1);
    chk("R7 survivor tag", head_tag[0], 8'h10);
    chk("R7 other thread", tail_slot[1], 1);
    chk("R6 retire after squash", can_commit[0], 1);
  endtask

  task automatic t_squash_none();
    do_reset();
    push(0, 10, 8'h55);
    sq_valid = 1; sq_thread = 0; sq_seq = 20;
    @(negedge clk);
    sq_valid = 0;
    chk("R8 none accepted", sq_done[0], 0);
    @(negedge clk);
    chk("R8 none one edge", sq_done[0], 1);
    chk("R7 older kept state", thr_state[0], 1);
    chk("R7 older kept tail", tail_slot[0], 1);
  endtask

  task automatic t_squash_ignored();
    do_reset();
    for (int i = 0; i < 6; i++) push(0, 10 + i, i);
    sq_valid = 1; sq_thread = 0; sq_seq = 13;
    @(negedge clk);
    sq_seq = 10;
    @(negedge clk);
    sq_valid = 0;
    wait_run(0);
    chk("R10 second squash ignored", tail_slot[0], 4);
    chk("R10 done", sq_done[0], 1);
  endtask

  initial begin
    t_reset();
    t_dispatch_commit();
    t_policy();
    t_full();
    t_squash_walk();
    t_squash_none();
    t_squash_ignored();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule